// File: doc/BRIEF.md
# Switchable Line Comb Filter Datapath

This block splits 8-bit video samples into a luminance (Y) stream and a chrominance (C) stream, one sample per clock on a single line-locked clock. In composite mode the input carries both components. A bandpass filter picks out the subcarrier band, and a low-pass filter gives a smoothed luma. Two cascaded line delays supply the same picture position from one or two lines earlier. Taking the difference of the bandpassed current and delayed samples gives a comb-separated chroma, which can then be subtracted from the composite centre sample to form Y.

An 8-bit static configuration word picks the operating mode at run time: the line length (625-line or 525-line timing), the comb span (one or two lines back), the input source (composite, or separate luma and chroma), how C is produced, whether Y has chroma removed, which chroma tap feeds that subtraction, and which of two filter characteristics is used. A bypass bit skips all filtering with a short fixed latency. The active path has a longer fixed latency that does not depend on the mode. Chroma is offset binary centred at 128, and both outputs are clamped to 0..255.

Top module: `yc_comb_split`

## Requirements
- R1: With cfg[0]=1 (bypass) no filtering is applied: y_out and c_out equal cv_in and c_in as sampled 3 clock edges earlier (the third register stage).
- R2: With cfg[0]=0, the sample sampled at edge k is the centre tap of the result that appears on y_out/c_out after edge k+20 (21 register stages). The current window at that output is the samples of edges e-17 down to e-23, where e is the output edge.
- R3: cfg[2] selects the line length: 0 gives 1728 samples per line delay and 1 gives 1716.
- R4: cfg[3] selects the comb span: 1 compares against the sample one line back and 0 compares against the sample two lines back (four-line mode).
- R5: With cfg[4]=1 (separate inputs), C is the bandpass of c_in and Y is the low-pass of cv_in; cfg[5], cfg[6] and cfg[7] have no effect.
- R6: In composite mode, cfg[5]=0 makes C the bandpass of the current window (bp) and cfg[5]=1 makes it the comb value cb=(bp-bp_delayed)>>>1 (arithmetic shift).
- R7: In composite mode, cfg[6]=0 makes Y the low-pass of the input. cfg[6]=1 makes Y equal the centre sample minus a chroma estimate.
- R8: In composite mode with cfg[6]=1, cfg[7]=0 subtracts bp and cfg[7]=1 subtracts cb.
- R9: cfg[1] selects the filters over the window x0 (newest) to x6. With 0: bandpass=(2x3-x1-x5)>>>2 and low-pass=(x2+2x3+x4)>>2. With 1: bandpass=(2x3-x0-x6)>>>2 and low-pass=(x1+2x3+x5)>>2.
- R10: c_out is 128 plus the selected chroma value; both outputs are clamped to the range 0..255.
- R11: While rst_n is low, a rising clock edge clears both outputs to 0.
- R12: When the active-mode inputs have been constant long enough to fill the filter window, the low-passed Y equals the input value and a bandpassed C equals 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line-locked sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg | input | 8 | Static mode word; bit fields as in R1 to R9 |
| cv_in | input | 8 | Composite samples, or luma in separate-input mode |
| c_in | input | 8 | Chroma samples (offset binary) for separate-input mode |
| y_out | output | 8 | Separated luminance |
| c_out | output | 8 | Separated chrominance, offset binary |

## Verification
In bypass, an output seen after edge e is due from the inputs of edge e-2. In active mode it is due from the window of edges e-17 to e-23, with the delayed window a further 1716 or 1728 samples (or twice that) further back. The bench logs every input against its edge number and recomputes each output from that log at the falling edge after each rising edge. After a change of the mode word, comparisons are held off for 3600 cycles, which is longer than two of the longest lines plus the pipeline. This ensures no compared output mixes data from two modes or two line lengths.

// File: rtl/yc_comb_split.sv
module yc_comb_split #(
  parameter int LINE_625 = 1728,
  parameter int LINE_525 = 1716,
  parameter int ACT_LAT  = 21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] cfg,
  input  logic [7:0] cv_in,
  input  logic [7:0] c_in,
  output logic [7:0] y_out,
  output logic [7:0] c_out
);

  localparam int DEPTH = (LINE_625 > LINE_525) ? LINE_625 : LINE_525;
  localparam int AW    = $clog2(DEPTH);
  localparam int PAD   = ACT_LAT - 7;
  localparam logic [AW-1:0] OFF_625 = AW'(LINE_625 - 1);
  localparam logic [AW-1:0] OFF_525 = AW'(LINE_525 - 1);

  logic bypass, fsel, l525, one_line, sep_yc, comb_c, y_sub, tap_cb;
  assign bypass   = cfg[0];
  assign fsel     = cfg[1];
  assign l525     = cfg[2];
  assign one_line = cfg[3];
  assign sep_yc   = cfg[4];
  assign comb_c   = cfg[5];
  assign y_sub    = cfg[6];
  assign tap_cb   = cfg[7];

  function automatic logic signed [10:0] bpf(input logic [6:0][7:0] v, input logic f);
    logic [7:0] e1, e2;
    logic signed [10:0] t;
    e1 = f ? v[0] : v[1];
    e2 = f ? v[6] : v[5];
    t = $signed({2'b00, v[3], 1'b0}) - $signed({3'b000, e1}) - $signed({3'b000, e2});
    return t >>> 2;
  endfunction

  function automatic logic [7:0] lpf(input logic [6:0][7:0] v, input logic f);
    logic [7:0] e1, e2;
    logic [9:0] s;
    e1 = f ? v[1] : v[2];
    e2 = f ? v[5] : v[4];
    s = {2'b00, e1} + {1'b0, v[3], 1'b0} + {2'b00, e2};
    return 8'(s >> 2);
  endfunction

  function automatic logic [7:0] sat8(input logic signed [10:0] x);
    if (x < 11'sd0)   return 8'd0;
    if (x > 11'sd255) return 8'd255;
    return x[7:0];
  endfunction

  logic [7:0] a_q, ca_q, yb_q, cb_q, l1_q, l2_q;
  logic [6:0][7:0] w_q, dw_q, cw_q;
  logic [AW-1:0] wp, rp, off;
  logic [7:0] mem1 [0:DEPTH-1];
  logic [7:0] mem2 [0:DEPTH-1];
  logic [7:0] r_y, r_c;
  logic [PAD-1:0][7:0] py, pc;

  assign off = l525 ? OFF_525 : OFF_625;
  assign rp  = wp - off + ((wp < off) ? AW'(DEPTH) : AW'(0));

  always_ff @(posedge clk) begin
    mem1[wp] <= a_q;
    mem2[wp] <= l1_q;
  end

  logic signed [10:0] bp_now, bp_old, bp_chr, dif, cmb, c_sel, c_sub;
  logic [7:0] lp_now, y_nxt, c_nxt;

  assign bp_now = bpf(w_q, fsel);
  assign bp_old = bpf(dw_q, fsel);
  assign bp_chr = bpf(cw_q, fsel);
  assign lp_now = lpf(w_q, fsel);
  assign dif    = bp_now - bp_old;
  assign cmb    = dif >>> 1;
  assign c_sel  = sep_yc ? bp_chr : (comb_c ? cmb : bp_now);
  assign c_sub  = tap_cb ? cmb : bp_now;
  assign y_nxt  = (sep_yc || !y_sub) ? lp_now
                                     : sat8($signed({3'b000, w_q[3]}) - c_sub);
  assign c_nxt  = sat8(11'sd128 + c_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      ca_q  <= '0;
      yb_q  <= '0;
      cb_q  <= '0;
      l1_q  <= '0;
      l2_q  <= '0;
      w_q   <= '0;
      dw_q  <= '0;
      cw_q  <= '0;
      wp    <= '0;
      r_y   <= '0;
      r_c   <= '0;
      py    <= '0;
      pc    <= '0;
      y_out <= '0;
      c_out <= '0;
    end else begin
      a_q   <= cv_in;
      ca_q  <= c_in;
      yb_q  <= a_q;
      cb_q  <= ca_q;
      wp    <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      l1_q  <= mem1[rp];
      l2_q  <= mem2[rp];
      w_q   <= {w_q[5:0], a_q};
      cw_q  <= {cw_q[5:0], ca_q};
      dw_q  <= {dw_q[5:0], (one_line ? l1_q : l2_q)};
      r_y   <= y_nxt;
      r_c   <= c_nxt;
      py    <= {py[PAD-2:0], r_y};
      pc    <= {pc[PAD-2:0], r_c};
      y_out <= bypass ? yb_q : py[PAD-1];
      c_out <= bypass ? cb_q : pc[PAD-1];
    end
  end

endmodule

// File: rtl/yc_comb_split_chk.sv
module yc_comb_split_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] cfg,
  input logic [7:0] cv_in,
  input logic [7:0] c_in,
  input logic [7:0] y_out,
  input logic [7:0] c_out
);

  logic [5:0] age, cv_run, ci_run, cfg_run;
  logic [7:0] pcv, pci, pcfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age <= '0; cv_run <= '0; ci_run <= '0; cfg_run <= '0;
      pcv <= '0; pci <= '0; pcfg <= '0;
    end else begin
      pcv  <= cv_in;
      pci  <= c_in;
      pcfg <= cfg;
      age     <= (age == 6'd63) ? age : age + 1'b1;
      cv_run  <= (cv_in != pcv) ? 6'd0 : ((cv_run == 6'd63) ? cv_run : cv_run + 1'b1);
      ci_run  <= (c_in != pci) ? 6'd0 : ((ci_run == 6'd63) ? ci_run : ci_run + 1'b1);
      cfg_run <= (cfg != pcfg) ? 6'd0 : ((cfg_run == 6'd63) ? cfg_run : cfg_run + 1'b1);
    end
  end

  a_r1_bypass_y: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 6'd4 && $past(cfg[0])) |-> y_out == $past(cv_in, 3));

  a_r1_bypass_c: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 6'd4 && $past(cfg[0])) |-> c_out == $past(c_in, 3));

  a_r12_dc_luma: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 6'd40 && cfg_run >= 6'd24 && cv_run >= 6'd24 && !cfg[0] && (cfg[4] || !cfg[6]))
      |-> y_out == $past(cv_in));

  a_r12_dc_chroma: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 6'd40 && cfg_run >= 6'd24 && !cfg[0] &&
     ((cfg[4] && ci_run >= 6'd24) || (!cfg[4] && !cfg[5] && cv_run >= 6'd24)))
      |-> c_out == 8'd128);

endmodule

bind yc_comb_split yc_comb_split_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .cv_in(cv_in), .c_in(c_in),
  .y_out(y_out), .c_out(c_out)
);

// File: tb/yc_comb_split_tb.sv
module yc_comb_split_tb;
  localparam int NH = 60000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] cfg = 8'h00, cv = 8'h00, ci = 8'h00;
  logic [7:0] yo, co;

  yc_comb_split u_dut (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cv_in(cv), .c_in(ci),
    .y_out(yo), .c_out(co)
  );

  always #2 clk = ~clk;

  int ec = -1;
  int hcv [NH];
  int hci [NH];
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    ec = ec + 1;
    if (ec < NH) begin
      hcv[ec] = int'(cv);
      hci[ec] = int'(ci);
    end
  end

  function automatic int smp(bit src, int i);
    return src ? hci[i] : hcv[i];
  endfunction

  function automatic int bpm(bit src, int b, bit f);
    int t;
    t = 2 * smp(src, b - 3) - (f ? smp(src, b) + smp(src, b - 6)
                                 : smp(src, b - 1) + smp(src, b - 5));
    return t >>> 2;
  endfunction

  function automatic int lpm(int b, bit f);
    int s;
    s = 2 * hcv[b - 3] + (f ? hcv[b - 1] + hcv[b - 5] : hcv[b - 2] + hcv[b - 4]);
    return s >> 2;
  endfunction

  function automatic int clamp(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction

  task automatic cmp(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at edge %0d: got %0d expected %0d", tag, what, ec, act, exp);
    end
  endtask

  task automatic check_out(string tag);
    int ey, ecx, b, d, bp0, bpd, cb;
    int llen;
    if (cfg[0]) begin
      ey  = hcv[ec - 2];
      ecx = hci[ec - 2];
    end else begin
      llen = cfg[2] ? 1716 : 1728;
      d    = cfg[3] ? llen : 2 * llen;
      b    = ec - 17;
      bp0  = bpm(1'b0, b, cfg[1]);
      bpd  = bpm(1'b0, b - d, cfg[1]);
      cb   = (bp0 - bpd) >>> 1;
      if (cfg[4]) begin
        ecx = clamp(128 + bpm(1'b1, b, cfg[1]));
        ey  = lpm(b, cfg[1]);
      end else begin
        ecx = clamp(128 + (cfg[5] ? cb : bp0));
        ey  = cfg[6] ? clamp(hcv[b - 3] - (cfg[7] ? cb : bp0)) : lpm(b, cfg[1]);
      end
    end
    cmp(tag, "y_out", int'(yo), ey);
    cmp(tag, "c_out", int'(co), ecx);
  endtask

  task automatic drive(int mode);
    case (mode)
      1: begin
        cv = ($urandom % 2) ? 8'd255 : 8'd0;
        ci = ($urandom % 2) ? 8'd255 : 8'd0;
      end
      2: begin
        cv = 8'd200;
        ci = 8'd60;
      end
      default: begin
        cv = 8'($urandom);
        ci = 8'($urandom);
      end
    endcase
  endtask

  task automatic run_phase(logic [7:0] val, int mode, string tag);
    @(negedge clk);
    cfg = val;
    drive(mode);
    repeat (3600) begin
      @(negedge clk);
      drive(mode);
    end
    repeat (400) begin
      @(negedge clk);
      check_out(tag);
      drive(mode);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    cmp("R11", "y_out in reset", int'(yo), 0);
    cmp("R11", "c_out in reset", int'(co), 0);
    rst_n = 1'b1;
    run_phase(8'h01, 0, "R1");
    run_phase(8'h00, 0, "R2");
    run_phase(8'h40, 0, "R7");
    run_phase(8'h60, 0, "R6");
    run_phase(8'hE0, 0, "R8");
    run_phase(8'hE8, 0, "R4");
    run_phase(8'hEC, 0, "R3");
    run_phase(8'hE4, 0, "R3");
    run_phase(8'hE2, 0, "R9");
    run_phase(8'hF0, 0, "R5");
    run_phase(8'h12, 0, "R5");
    run_phase(8'hE0, 1, "R10");
    run_phase(8'h00, 2, "R12");
    run_phase(8'h01, 1, "R1");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule